// File: doc/BRIEF.md
# Cascaded Prioritized Interrupt Controller

This block gathers 96 interrupt sources into one CPU interrupt line. The sources come in three 32-bit groups. The main low group gives interrupt numbers 0 to 31 and the main high group gives 32 to 63. The port group gives 64 to 95 and sits behind four summary bits of the high group. Each group has a cause register and a mask register. All of them sit on a small register bus with a single-cycle write strobe and a combinational read port.

Software reads one vector register to learn which interrupt to service next. The vector comes from a fixed search:

- The low group is searched first.
- The high group is searched only when the low group has no candidate.
- A winning summary bit sends the search down into the port group.

Each main group also has a fixed eligibility pattern that keeps some of its bits out of the search. When a summary bit wins but no enabled port source sits behind it, a distinct "no valid interrupt" code is returned.

Low- and high-group causes follow level sources. Port-group causes capture rising edges and hold them until software clears them with a write-zero-to-clear rule.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: The vector reports low-group bit i as number i, high-group bit i as 32+i, and port-group bit i as 64+i. The vector register sits at address 6: bit 7 is the valid flag, bits 6:0 hold the number, and bits 31:8 read 0.
- R2: A mask bit of 1 lets its cause bit take part in the vector search and in the CPU line. A mask bit of 0 keeps it out. Mask registers change only when software writes them: low mask at address 3, high mask at address 4, port mask at address 5.
- R3: Only low-group bits in 0x3DFFFFFE and high-group bits in 0x0F000DB7 can win the vector search or raise the CPU line. All other bits have no effect on either.
- R4: Any enabled, eligible, pending low-group bit wins over every high-group and port-group source.
- R5: Within a group, the lowest-numbered enabled, eligible, pending bit wins.
- R6: High-group bit 24+k (k = 0..3) is the OR of the port-group cause bits 8k..8k+7, ignoring the port mask; the high-group source inputs 24..27 are not used. When such a summary bit wins, the vector is 64 plus the lowest enabled, pending port-group bit.
- R7: When nothing qualifies, or when a summary bit wins with no enabled, pending port bit, the vector reads valid=0 with number 127 (0x7F).
- R8: A write to the port cause register (address 2) clears each cause bit written as 0 and keeps each bit written as 1.
- R9: A rising edge on a port input sets its cause bit, and the bit stays set until cleared. An input held high after a clear does not set the bit again.
- R10: After reset all causes are 0, the low and port masks are 0, the high mask is 0x0F000000, the vector reads 0x7F and the CPU line is low.
- R11: The CPU line is a register holding the OR of all enabled, eligible low- and high-group cause bits, summaries included. It rises one clock after the enabling cause and mask are both present.
- R12: Addresses 0 and 1 return the low and high causes. These follow their source inputs with one clock of delay, and the high read shows the summaries in bits 24..27. Writes to addresses 0, 1, 6 and 7 are ignored, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lo | input | 32 | Low-group level sources |
| src_hi | input | 32 | High-group level sources (bits 24..27 unused) |
| gpp_in | input | 32 | Port-group edge sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data (combinational) |
| cpu_irq | output | 1 | CPU interrupt request |

## Verification
The hardest situation to reach is the cascade dead end: a summary bit wins while the port mask hides every source behind it. Reaching it needs a port cause set by an edge, a summary left enabled in the high mask, and an empty low group all at once. The bench reaches it by loading causes through edges on `gpp_in` with the port mask written to zero, and then checks for the 0x7F code while the CPU line stays high. A long run of pseudo-random mask and cause patterns then compares every vector against an arithmetic model of the cascaded search.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_LO_CAUSE  = 3'd0,
        RA_HI_CAUSE  = 3'd1,
        RA_GPP_CAUSE = 3'd2,
        RA_LO_MASK   = 3'd3,
        RA_HI_MASK   = 3'd4,
        RA_GPP_MASK  = 3'd5,
        RA_VECTOR    = 3'd6,
        RA_SPARE     = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/irq_gpp_bank.sv
module irq_gpp_bank #(
    parameter int GW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] gpp_in,
    input  logic          clr_we,
    input  logic [GW-1:0] clr_keep,
    output logic [GW-1:0] cause
);
    typedef struct packed {
        logic [GW-1:0] cause;
        logic [GW-1:0] prev;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        logic [GW-1:0] keep;
        keep       = clr_we ? clr_keep : '1;
        st_d.cause = (st_q.cause & keep) | (gpp_in & ~st_q.prev);
        st_d.prev  = gpp_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause = st_q.cause;

    // R9
    gpp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((st_q.cause & $past(gpp_in & ~st_q.prev)) == $past(gpp_in & ~st_q.prev)));

    // R8
    gpp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr_we)) |-> ((st_q.cause & $past(st_q.cause)) == $past(st_q.cause)));
endmodule

// File: rtl/irq_vector_resolve.sv
module irq_vector_resolve #(
    parameter int            GW      = 32,
    parameter int            SUM_LSB = 24,
    parameter logic [GW-1:0] LO_ELIG = 32'h3DFF_FFFE,
    parameter logic [GW-1:0] HI_ELIG = 32'h0F00_0DB7,
    parameter int            NUM_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GW-1:0]    lo_cause,
    input  logic [GW-1:0]    hi_cause,
    input  logic [GW-1:0]    gpp_cause,
    input  logic [GW-1:0]    lo_mask,
    input  logic [GW-1:0]    hi_mask,
    input  logic [GW-1:0]    gpp_mask,
    output logic             vec_valid,
    output logic [NUM_W-1:0] vec_num,
    output logic             main_hit
);
    localparam int IDX_W = $clog2(GW);

    function automatic logic [IDX_W-1:0] first_set(input logic [GW-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = GW - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    logic [GW-1:0]    lo_c, hi_c, gp_c;
    logic [IDX_W-1:0] hi_idx;

    always_comb begin
        lo_c      = lo_cause & lo_mask & LO_ELIG;
        hi_c      = hi_cause & hi_mask & HI_ELIG;
        gp_c      = gpp_cause & gpp_mask;
        hi_idx    = first_set(hi_c);
        main_hit  = (|lo_c) || (|hi_c);
        vec_valid = 1'b0;
        vec_num   = '1;
        if (|lo_c) begin
            vec_valid = 1'b1;
            vec_num   = NUM_W'(first_set(lo_c));
        end else if (|hi_c) begin
            if (int'(hi_idx) >= SUM_LSB) begin
                if (|gp_c) begin
                    vec_valid = 1'b1;
                    vec_num   = NUM_W'(2 * GW) + NUM_W'(first_set(gp_c));
                end
            end else begin
                vec_valid = 1'b1;
                vec_num   = NUM_W'(GW) + NUM_W'(hi_idx);
            end
        end
    end

    // R7
    bogus_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_num == '1));

    // R4
    low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lo_cause & lo_mask & LO_ELIG)) |-> (vec_valid && vec_num < NUM_W'(GW)));

    // R6
    cascade_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_num >= NUM_W'(2 * GW)) |-> ((gpp_cause & gpp_mask) != '0));
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int            GW          = 32,
    parameter int            NSUM        = 4,
    parameter int            SUM_LSB     = 24,
    parameter logic [GW-1:0] LO_ELIG     = 32'h3DFF_FFFE,
    parameter logic [GW-1:0] HI_ELIG     = 32'h0F00_0DB7,
    parameter logic [GW-1:0] HI_MASK_RST = 32'h0F00_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GW-1:0]     src_lo,
    input  logic [GW-1:0]     src_hi,
    input  logic [GW-1:0]     gpp_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [GW-1:0]     wr_data,
    output logic [GW-1:0]     rd_data,
    output logic              cpu_irq
);
    localparam int            NUM_W     = $clog2(3 * GW);
    localparam int            SEG       = GW / NSUM;
    localparam logic [GW-1:0] SUM_FIELD = GW'(((1 << NSUM) - 1) << SUM_LSB);

    typedef struct packed {
        logic [GW-1:0] lo_lvl;
        logic [GW-1:0] hi_lvl;
        logic [GW-1:0] mask_lo;
        logic [GW-1:0] mask_hi;
        logic [GW-1:0] mask_gpp;
        logic          irq;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [GW-1:0]    gpp_cause, hi_view;
    logic [NSUM-1:0]  summary;
    logic             vec_valid, main_hit;
    logic [NUM_W-1:0] vec_num;

    irq_gpp_bank #(.GW(GW)) u_gpp (
        .clk      (clk),
        .rst_n    (rst_n),
        .gpp_in   (gpp_in),
        .clr_we   (wr_en && (reg_addr_e'(addr) == RA_GPP_CAUSE)),
        .clr_keep (wr_data),
        .cause    (gpp_cause)
    );

    for (genvar k = 0; k < NSUM; k++) begin : g_sum
        assign summary[k] = |gpp_cause[k*SEG +: SEG];
    end

    assign hi_view = (st_q.hi_lvl & ~SUM_FIELD) | (GW'(summary) << SUM_LSB);

    irq_vector_resolve #(
        .GW(GW), .SUM_LSB(SUM_LSB), .LO_ELIG(LO_ELIG), .HI_ELIG(HI_ELIG), .NUM_W(NUM_W)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_cause  (st_q.lo_lvl),
        .hi_cause  (hi_view),
        .gpp_cause (gpp_cause),
        .lo_mask   (st_q.mask_lo),
        .hi_mask   (st_q.mask_hi),
        .gpp_mask  (st_q.mask_gpp),
        .vec_valid (vec_valid),
        .vec_num   (vec_num),
        .main_hit  (main_hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.lo_lvl = src_lo;
        st_d.hi_lvl = src_hi;
        st_d.irq    = main_hit;
        if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_LO_MASK:  st_d.mask_lo  = wr_data;
                RA_HI_MASK:  st_d.mask_hi  = wr_data;
                RA_GPP_MASK: st_d.mask_gpp = wr_data;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.mask_hi <= HI_MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_LO_CAUSE:  rd_data = st_q.lo_lvl;
            RA_HI_CAUSE:  rd_data = hi_view;
            RA_GPP_CAUSE: rd_data = gpp_cause;
            RA_LO_MASK:   rd_data = st_q.mask_lo;
            RA_HI_MASK:   rd_data = st_q.mask_hi;
            RA_GPP_MASK:  rd_data = st_q.mask_gpp;
            RA_VECTOR:    rd_data = GW'({vec_valid, vec_num});
            default:      rd_data = '0;
        endcase
    end

    assign cpu_irq = st_q.irq;

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |->
            ($stable(st_q.mask_lo) && $stable(st_q.mask_hi) && $stable(st_q.mask_gpp)));
endmodule

// File: tb/sim_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cascade_ctrl;
    localparam logic [31:0] LO_EL = 32'h3DFF_FFFE;
    localparam logic [31:0] HI_EL = 32'h0F00_0DB7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lo = '0, src_hi = '0, gpp_in = '0, wr_data = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] rd_data;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_cascade_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_hi(src_hi), .gpp_in(gpp_in),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] hi_eff(input logic [31:0] hi, input logic [31:0] gc);
        logic [31:0] r;
        r = hi & ~32'h0F00_0000;
        for (int k = 0; k < 4; k++) r[24+k] = |gc[8*k +: 8];
        return r;
    endfunction

    function automatic logic [31:0] model_vec(input logic [31:0] lo, hi, gc, mlo, mhi, mg);
        logic [31:0] l, h, g;
        l = lo & mlo & LO_EL;
        h = hi_eff(hi, gc) & mhi & HI_EL;
        g = gc & mg;
        if (l != 0) return 32'h80 | lowest(l);
        if (h != 0) begin
            if (lowest(h) >= 24) begin
                if (g != 0) return 32'h80 | (64 + lowest(g));
                return 32'h7F;
            end
            return 32'h80 | (32 + lowest(h));
        end
        return 32'h7F;
    endfunction

    function automatic logic model_irq(input logic [31:0] lo, hi, gc, mlo, mhi);
        return ((lo & mlo & LO_EL) != 0) || ((hi_eff(hi, gc) & mhi & HI_EL) != 0);
    endfunction

    // Loads masks and causes, then waits until the CPU line reflects them.
    task automatic load(input logic [31:0] lo, hi, gc, mlo, mhi, mg);
        wr(3'd3, mlo);
        wr(3'd4, mhi);
        wr(3'd5, mg);
        wr(3'd2, 32'h0);
        gpp_in = gc; src_lo = lo; src_hi = hi;
        @(negedge clk);
        gpp_in = '0;
        @(negedge clk);
    endtask

    task automatic check_state(input string req, input logic [31:0] lo, hi, gc, mlo, mhi, mg);
        logic [31:0] v;
        rd(3'd6, v);
        chk({req, " vector"}, v, model_vec(lo, hi, gc, mlo, mhi, mg));
        chk({req, " cpu_irq"}, {31'b0, cpu_irq}, {31'b0, model_irq(lo, hi, gc, mlo, mhi)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(3'd0, v); chk("R10 lo cause", v, 32'h0);
        rd(3'd1, v); chk("R10 hi cause", v, 32'h0);
        rd(3'd2, v); chk("R10 gpp cause", v, 32'h0);
        rd(3'd3, v); chk("R10 lo mask", v, 32'h0);
        rd(3'd4, v); chk("R10 hi mask", v, 32'h0F00_0000);
        rd(3'd5, v); chk("R10 gpp mask", v, 32'h0);
        rd(3'd6, v); chk("R10 vector", v, 32'h7F);
        chk("R10 cpu_irq", {31'b0, cpu_irq}, 32'h0);

        // R12 read-only causes, one-cycle follow, spare address
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R12 lo cause write ignored", v, 32'h0);
        rd(3'd7, v); chk("R12 spare reads zero", v, 32'h0);
        src_lo = 32'h0000_00F0; src_hi = 32'hFFFF_FFFF;
        rd(3'd0, v); chk("R12 lo cause before edge", v, 32'h0);
        @(negedge clk);
        rd(3'd0, v); chk("R12 lo cause after edge", v, 32'h0000_00F0);
        rd(3'd1, v); chk("R12 hi cause summaries", v, 32'hF0FF_FFFF);
        src_lo = '0; src_hi = '0;
        @(negedge clk);

        // R11 latency and R2 masking of CPU line
        wr(3'd3, 32'h0000_0002);
        src_lo = 32'h0000_0002;
        @(negedge clk);
        chk("R11 irq not yet", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        chk("R11 irq one clock after", {31'b0, cpu_irq}, 32'h1);
        wr(3'd3, 32'h0);
        @(negedge clk);
        chk("R2 masked irq drops", {31'b0, cpu_irq}, 32'h0);
        rd(3'd6, v); chk("R2 masked vector", v, 32'h7F);
        src_lo = '0;

        // R1 R3 R5 single-bit sweeps over low and high groups
        for (int i = 0; i < 32; i++) begin
            load(32'h1 << i, 0, 0, 32'hFFFF_FFFF, 32'h0F00_0000, 0);
            check_state("R1 R3 lo sweep", 32'h1 << i, 0, 0, 32'hFFFF_FFFF, 32'h0F00_0000, 0);
        end
        for (int i = 0; i < 32; i++) begin
            load(0, 32'h1 << i, 0, 0, 32'hFFFF_FFFF, 0);
            check_state("R1 R3 hi sweep", 0, 32'h1 << i, 0, 0, 32'hFFFF_FFFF, 0);
        end

        // R6 R8 port sweep: set by edge, vector 64+i, clear one bit by inverse
        for (int i = 0; i < 32; i++) begin
            load(0, 0, 32'h1 << i, 0, 32'h0F00_0000, 32'hFFFF_FFFF);
            check_state("R6 gpp sweep", 0, 0, 32'h1 << i, 0, 32'h0F00_0000, 32'hFFFF_FFFF);
            wr(3'd2, ~(32'h1 << i));
            rd(3'd2, v); chk("R8 single clear", v, 32'h0);
        end

        // R8 keep ones, clear zeros
        load(0, 0, 32'h0000_00FF, 0, 32'h0F00_0000, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFE);
        rd(3'd2, v); chk("R8 partial clear", v, 32'h0000_00FE);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R8 all-ones keeps", v, 32'h0000_00FE);
        rd(3'd6, v); chk("R5 gpp lowest wins", v, 32'h80 | 65);

        // R9 held-high input does not re-set after clear
        wr(3'd2, 32'h0);
        gpp_in = 32'h0001_0000;
        @(negedge clk);
        wr(3'd2, 32'h0);
        @(negedge clk);
        rd(3'd2, v); chk("R9 held high no reset", v, 32'h0);
        gpp_in = '0;
        @(negedge clk);
        gpp_in = 32'h0001_0000;
        @(negedge clk);
        rd(3'd2, v); chk("R9 new edge sets", v, 32'h0001_0000);
        gpp_in = '0;

        // R7 summary wins with port mask hiding the source
        load(0, 0, 32'h0000_0100, 0, 32'h0F00_0000, 32'h0);
        rd(3'd6, v); chk("R7 dead-end summary", v, 32'h7F);
        chk("R7 R11 summary still raises irq", {31'b0, cpu_irq}, 32'h1);

        // R4 low beats high and port
        load(32'h0000_0800, 32'h0000_0001, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_state("R4 low first", 32'h0000_0800, 32'h0000_0001, 32'h1,
                    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R4 R5 R6 R7 pseudo-random patterns against the model
        seed = 32'h1234_5678;
        for (int n = 0; n < 300; n++) begin
            logic [31:0] p[6];
            for (int j = 0; j < 6; j++) begin
                seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
                p[j] = seed & ((n % 3 == 0) ? seed >> 7 : 32'hFFFF_FFFF);
            end
            if (n % 4 == 0) p[0] = '0;
            load(p[0], p[1], p[2], p[3], p[4], p[5]);
            check_state("R4 R5 R6 R7 random", p[0], p[1], p[2], p[3], p[4], p[5]);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule